// File: doc/BRIEF.md
# Disk-Channel Interrupt Status Unit

This unit collects the two event sources of a single-channel disk-interface DMA engine (the attached drive's interrupt and a host-bus error seen while the DMA engine moves data) into sticky status bits, gates them with an enable mask and drives one level-sensitive interrupt line to the host. Software reaches it through a 32-bit register bus addressed by word index. It reads the status word to see which source fired, writes ones to a clear word to acknowledge them, and writes ones to a set word to enable sources at start-up. When a bus error is latched, the 64-bit address of the failing bus cycle is frozen in two read-only words so that software can report it.

The drive itself is not modelled. A strobe marks each host read of the drive's status byte and carries that byte's value. When the value shows the drive is no longer busy (any of bits 0, 4 or 6 set), the read also acknowledges both pending status bits, the same as an explicit clear. A busy-only value (bit 7) leaves them pending, so software that polls the busy bit does not lose the event.

Reads have no side effects and return data in the same cycle as the word index. Writes and strobes take effect at the next rising clock edge.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status bits, the enable mask and both captured-address words read zero and `irq_o` is low.
- R2: Word map for reads: word 3 returns the status in bits [1:0] (bit 0 = drive interrupt, bit 1 = bus error), word 5 returns the enable mask in bits [1:0], word 0 returns captured address bits [31:0], word 1 returns bits [63:32]. All other words and all unused bits read zero.
- R3: A `dev_irq_evt` strobe sets status bit 0 and a `bus_err_evt` strobe sets status bit 1 at the next edge, whatever the enable mask holds.
- R4: If an event and a clear (by register write or by drive-status read) act on the same bit in the same cycle, the bit ends set.
- R5: A write to word 7 clears each status bit whose `reg_wdata` bit (bit 0 or 1) is 1 and leaves the other bit unchanged.
- R6: A write to word 5 ORs `reg_wdata[1:0]` into the enable mask; zero bits never clear an enable bit.
- R7: `irq_o` is high exactly when some status bit and its enable bit are both set.
- R8: On `bus_err_evt` the 64-bit `bus_err_addr` is captured when status bit 1 is clear or is being cleared in that cycle; while status bit 1 stays set the captured address does not change.
- R9: A `devstat_rd` strobe whose `devstat_val` has any of bits 0, 4 or 6 set clears both status bits at the next edge; a value without those bits (for example 0x80, busy) leaves them unchanged.
- R10: Writes to words other than 5 and 7 change neither the status bits nor the enable mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Word index for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_idx`, same cycle |
| dev_irq_evt | input | 1 | Drive interrupt event strobe |
| bus_err_evt | input | 1 | Host-bus DMA error event strobe |
| bus_err_addr | input | 64 | Address of the failing bus cycle, valid with `bus_err_evt` |
| devstat_rd | input | 1 | Host read of the drive status byte |
| devstat_val | input | 8 | Value of the drive status byte being read |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
The assertions take for granted that all inputs are low while reset is applied and for the cycles of the internal reset release, and that inputs change only away from the rising edge, so each strobe is sampled as held for whole cycles. They also assume a single register access per cycle, so a write and a drive-status read may coincide only as described in R4. The stimulus drives every input at the falling edge, holds each strobe for exactly one cycle, waits several cycles after reset before the first stimulus, and reads results after the following falling edge.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int unsigned NSRC     = 2;
  localparam int unsigned IDX_W    = 3;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 64;
  localparam int unsigned STAT_W   = 8;

  localparam logic [IDX_W-1:0] W_ADDR_LO = 3'd0;
  localparam logic [IDX_W-1:0] W_ADDR_HI = 3'd1;
  localparam logic [IDX_W-1:0] W_STATUS  = 3'd3;
  localparam logic [IDX_W-1:0] W_SET     = 3'd5;
  localparam logic [IDX_W-1:0] W_CLEAR   = 3'd7;

  localparam int unsigned SRC_DEV = 0;
  localparam int unsigned SRC_ERR = 1;

  localparam logic [STAT_W-1:0] NOT_BUSY_MASK = 8'h51;

  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/isc_evt_latch.sv
module isc_evt_latch
  import isc_pkg::*;
#(
  parameter int unsigned N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  output logic [N-1:0] sts
);
  logic [N-1:0] sts_nxt;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      sts_nxt[i] = sts[i];
      if (clr[i]) sts_nxt[i] = 1'b0;
      if (evt[i]) sts_nxt[i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts[i] <= 1'b0;
      else if (evt[i] || clr[i]) sts[i] <= sts_nxt[i];
    end

    // R3 and R4: an event always leaves its bit set
    a_r4_evt_wins: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> sts[i]);
    // R5: a clear without an event empties the bit
    a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !evt[i]) |=> !sts[i]);
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr[i] && !evt[i]) |=> $stable(sts[i]));
  end
endmodule

// File: rtl/isc_en_mask.sv
module isc_en_mask
  import isc_pkg::*;
#(
  parameter int unsigned N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_wr,
  input  logic [N-1:0] set_bits,
  output logic [N-1:0] en
);
  logic [N-1:0] en_nxt;

  always_comb begin
    en_nxt = en | set_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en <= '0;
    else if (set_wr) en <= en_nxt;
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R6: an enable bit once set never drops
    a_r6_en_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      en[i] |=> en[i]);
    a_r6_en_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!en[i] && !set_wr) |=> !en[i]);
  end
endmodule

// File: rtl/isc_err_capture.sv
module isc_err_capture
  import isc_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          err_evt,
  input  logic          err_held,
  input  logic          err_clr,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_q
);
  logic          cap_en;
  logic [AW-1:0] addr_nxt;

  always_comb begin
    cap_en   = err_evt && (!err_held || err_clr);
    addr_nxt = cap_en ? addr_in : addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else if (cap_en) addr_q <= addr_nxt;
  end

  // R8: address frozen while the error bit stays held
  a_r8_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (err_held && !err_clr) |=> $stable(addr_q));
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import isc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              dev_irq_evt,
  input  logic              bus_err_evt,
  input  logic [ADDR_W-1:0] bus_err_addr,
  input  logic              devstat_rd,
  input  logic [STAT_W-1:0] devstat_val,
  output logic              irq_o
);
  localparam int unsigned HALF = ADDR_W / 2;

  logic       rst_s1, rst_s2;
  src_vec_t   evt_v, clr_v, sts, en;
  logic       wr_set, wr_clr, ds_hit;
  logic [ADDR_W-1:0] err_addr_q;

  // reset: asserted at once, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  always_comb begin
    wr_set = reg_wr && (reg_idx == W_SET);
    wr_clr = reg_wr && (reg_idx == W_CLEAR);
    ds_hit = devstat_rd && ((devstat_val & NOT_BUSY_MASK) != '0);
    evt_v  = '0;
    evt_v[SRC_DEV] = dev_irq_evt;
    evt_v[SRC_ERR] = bus_err_evt;
    clr_v  = (wr_clr ? reg_wdata[NSRC-1:0] : '0) | (ds_hit ? '1 : '0);
  end

  isc_evt_latch #(.N(NSRC)) u_latch (
    .clk(clk), .rst_n(rst_s2), .evt(evt_v), .clr(clr_v), .sts(sts)
  );

  isc_en_mask #(.N(NSRC)) u_mask (
    .clk(clk), .rst_n(rst_s2), .set_wr(wr_set),
    .set_bits(reg_wdata[NSRC-1:0]), .en(en)
  );

  isc_err_capture #(.AW(ADDR_W)) u_cap (
    .clk(clk), .rst_n(rst_s2), .err_evt(bus_err_evt),
    .err_held(sts[SRC_ERR]), .err_clr(clr_v[SRC_ERR]),
    .addr_in(bus_err_addr), .addr_q(err_addr_q)
  );

  always_comb begin
    irq_o = |(sts & en);
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_idx)
      W_ADDR_LO: reg_rdata = err_addr_q[HALF-1:0];
      W_ADDR_HI: reg_rdata = err_addr_q[ADDR_W-1:HALF];
      W_STATUS:  reg_rdata[NSRC-1:0] = sts;
      W_SET:     reg_rdata[NSRC-1:0] = en;
      default:   reg_rdata = '0;
    endcase
  end

  // R7: the line only rises after an event or an enable write
  a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_s2)
    $rose(irq_o) |-> $past(dev_irq_evt || bus_err_evt || wr_set));
  // R9: busy-only drive status keeps pending bits
  a_r9_busy_keeps: assert property (@(posedge clk) disable iff (!rst_s2)
    (devstat_rd && !ds_hit && !reg_wr && sts[SRC_DEV]) |=> sts[SRC_DEV]);
  // R10: writes elsewhere leave the enable mask alone
  a_r10_other_word: assert property (@(posedge clk) disable iff (!rst_s2)
    (reg_wr && reg_idx != W_SET) |=> $stable(en));
endmodule

// File: tb/irq_status_ctrl_tb.sv
module irq_status_ctrl_tb;
  logic        clk, rst_n;
  logic        reg_wr;
  logic [2:0]  reg_idx;
  logic [31:0] reg_wdata, reg_rdata;
  logic        dev_irq_evt, bus_err_evt, devstat_rd, irq_o;
  logic [63:0] bus_err_addr;
  logic [7:0]  devstat_val;
  int          n_chk, n_bad;

  irq_status_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dev_irq_evt(dev_irq_evt), .bus_err_evt(bus_err_evt),
    .bus_err_addr(bus_err_addr), .devstat_rd(devstat_rd),
    .devstat_val(devstat_val), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // one cycle of stimulus applied at the falling edge, removed at the next
  task automatic cyc(input logic wr, input logic [2:0] idx, input logic [31:0] wd,
                     input logic dev, input logic err, input logic [63:0] addr,
                     input logic dsrd, input logic [7:0] dsval);
    @(negedge clk);
    reg_wr = wr; reg_idx = idx; reg_wdata = wd;
    dev_irq_evt = dev; bus_err_evt = err; bus_err_addr = addr;
    devstat_rd = dsrd; devstat_val = dsval;
    @(negedge clk);
    reg_wr = 1'b0; dev_irq_evt = 1'b0; bus_err_evt = 1'b0;
    devstat_rd = 1'b0; devstat_val = 8'h00; bus_err_addr = '0;
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] wd);
    cyc(1'b1, idx, wd, 1'b0, 1'b0, 64'h0, 1'b0, 8'h00);
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] v);
    reg_idx = idx;
    #1;
    v = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rst_n = 1'b0;
    reg_wr = 0; reg_idx = 0; reg_wdata = 0; dev_irq_evt = 0; bus_err_evt = 0;
    bus_err_addr = 0; devstat_rd = 0; devstat_val = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(3'd3, v); chk("R1 status", v, 0);
    rd(3'd5, v); chk("R1 enable", v, 0);
    rd(3'd0, v); chk("R1 addr lo", v, 0);
    rd(3'd1, v); chk("R1 addr hi", v, 0);
    chk("R1 irq", {31'b0, irq_o}, 0);
  endtask

  task automatic t_events;
    logic [31:0] v;
    cyc(0, 0, 0, 1, 0, 64'h0, 0, 0);
    rd(3'd3, v); chk("R3 dev bit", v, 32'h1);
    chk("R7 masked irq", {31'b0, irq_o}, 0);
    cyc(0, 0, 0, 0, 1, 64'h11223344_55667788, 0, 0);
    rd(3'd3, v); chk("R3 err bit", v, 32'h3);
    rd(3'd0, v); chk("R8 R2 addr lo", v, 32'h55667788);
    rd(3'd1, v); chk("R8 R2 addr hi", v, 32'h11223344);
    cyc(0, 0, 0, 0, 1, 64'hAAAAAAAA_BBBBBBBB, 0, 0);
    rd(3'd0, v); chk("R8 frozen lo", v, 32'h55667788);
    rd(3'd1, v); chk("R8 frozen hi", v, 32'h11223344);
  endtask

  task automatic t_enable;
    logic [31:0] v;
    wr(3'd5, 32'h1);
    rd(3'd5, v); chk("R6 enable set", v, 32'h1);
    chk("R7 irq on", {31'b0, irq_o}, 1);
    wr(3'd5, 32'h0);
    rd(3'd5, v); chk("R6 zero keeps", v, 32'h1);
    wr(3'd4, 32'h3);
    wr(3'd3, 32'h0);
    rd(3'd5, v); chk("R10 enable", v, 32'h1);
    rd(3'd3, v); chk("R10 status", v, 32'h3);
    rd(3'd6, v); chk("R2 unused word", v, 0);
  endtask

  task automatic t_clear;
    logic [31:0] v;
    wr(3'd7, 32'h1);
    rd(3'd3, v); chk("R5 clear bit0", v, 32'h2);
    chk("R7 irq off", {31'b0, irq_o}, 0);
    wr(3'd5, 32'h2);
    chk("R7 err enabled", {31'b0, irq_o}, 1);
    wr(3'd7, 32'h2);
    rd(3'd3, v); chk("R5 clear bit1", v, 0);
    chk("R7 irq off2", {31'b0, irq_o}, 0);
  endtask

  task automatic t_race;
    logic [31:0] v;
    cyc(1, 3'd7, 32'h3, 1, 0, 64'h0, 0, 0);
    rd(3'd3, v); chk("R4 dev wins", v, 32'h1);
    wr(3'd7, 32'h1);
    cyc(0, 0, 0, 0, 1, 64'h00000001_00000002, 0, 0);
    cyc(1, 3'd7, 32'h2, 0, 1, 64'h00000003_00000004, 0, 0);
    rd(3'd3, v); chk("R4 err wins", v, 32'h2);
    rd(3'd0, v); chk("R8 recapture lo", v, 32'h4);
    rd(3'd1, v); chk("R8 recapture hi", v, 32'h3);
    wr(3'd7, 32'h3);
    cyc(0, 0, 0, 1, 0, 64'h0, 1, 8'h40);
    rd(3'd3, v); chk("R4 dev wins devstat", v, 32'h1);
    wr(3'd7, 32'h3);
  endtask

  task automatic t_devstat;
    logic [31:0] v;
    cyc(0, 0, 0, 1, 1, 64'h0, 0, 0);
    cyc(0, 0, 0, 0, 0, 64'h0, 1, 8'h80);
    rd(3'd3, v); chk("R9 busy keeps", v, 32'h3);
    cyc(0, 0, 0, 0, 0, 64'h0, 1, 8'h40);
    rd(3'd3, v); chk("R9 bit6 clears", v, 0);
    chk("R9 irq off", {31'b0, irq_o}, 0);
    cyc(0, 0, 0, 1, 0, 64'h0, 0, 0);
    cyc(0, 0, 0, 0, 0, 64'h0, 1, 8'h01);
    rd(3'd3, v); chk("R9 bit0 clears", v, 0);
    cyc(0, 0, 0, 0, 1, 64'h0, 0, 0);
    cyc(0, 0, 0, 0, 0, 64'h0, 1, 8'h10);
    rd(3'd3, v); chk("R9 bit4 clears", v, 0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    t_reset;
    t_events;
    t_enable;
    t_clear;
    t_race;
    t_devstat;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule